// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block watches eight external input lines and turns their settled levels into level-sensitive interrupts. Each raw input is first brought into the clock domain through a two-flop synchroniser. It then passes a per-line filter that accepts a new level only after that level has held for a programmable number of millisecond ticks. The millisecond tick is an input strobe, one clock wide, made outside the block. A filtered level that matches the line's programmed active level raises that line's status bit. This happens only when the line has been armed. Arming is single-shot: the hardware drops the arm bit when it raises the status bit, and software must arm the line again to take another interrupt. Edge behaviour is left to software, which flips the active level after each event.

Software reaches the bank through a simple register port: an address, write data, a write strobe and a read strobe. Read data is registered and appears the cycle after the read strobe. A single interrupt output is the OR of all status bits whose enable is set. Bit n of every line-wide register belongs to line n.

Top module: `dbirq_bank`

## Requirements
- R1: During reset (rst_n low at a clock edge) every register clears. After reset, every readable register reads 0, reg_rdata is 0 and irq_o is low.
- R2: The read/write registers keep what was written and read back the cycle after the reg_rd edge: mask-enable at 0x04, active level at 0x14, interrupt enable at 0x18, arm at 0x28. The per-line settle time for line n is at 0x40+4*n and keeps only bits 11:0. An unmapped address, or the clear register at 0x24, reads 0. Writes to read-only addresses change nothing. reg_rdata holds its value while reg_rd is low.
- R3: A line's filtered level takes a new input value only after the synchronised input (two flops) has differed from the filtered level on as many tick_ms cycles as the programmed settle time. If the input returns to the filtered level before then, the count starts again.
- R4: A settle time of 0 behaves as a settle time of 1 tick.
- R5: The data register at 0x00 returns the filtered level ANDed with the mask-enable register, so a line with mask-enable 0 reads 0.
- R6: Status bit n (read at 0x1C) is set in the cycle after its line is both armed and at its active level. It stays set until software writes 1 to bit n at 0x24. Writing 0 there has no effect, and a new set wins over a clear in the same cycle.
- R7: The masked status at 0x20 is the status ANDed with the interrupt enable, and irq_o is high exactly when any masked status bit is 1.
- R8: When a line's status sets, the hardware clears its arm bit in the same edge. The line raises no further status until software writes its arm bit to 1 again. A software write to the arm register wins over the hardware clear.
- R9: An active-level bit of 1 makes the line active while its filtered level is 1. A bit of 0 makes it active while its filtered level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond strobe that advances the settle counters |
| line_in | input | 8 | Raw external input lines, asynchronous |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; data is on reg_rdata the next cycle |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt, OR of masked status bits |

## Verification
A settle counter that is wrong shows up at the data register as a level change one or more ticks early or late. A counter that fails to restart after a glitch lets a pulse through that should have been filtered. An arm bit that does not clear itself shows as a status bit that sets again within one cycle after a clear, instead of staying low until software arms the line. Since status and enable feed irq_o directly, a wrong status bit reaches the interrupt pin in the same cycle it is stored. The bench compares the register port and irq_o against its reference model on every clock, so a divergence is reported on the cycle it first becomes visible.

// File: rtl/dbirq_pkg.sv
// Shared constants for the debounced level interrupt bank.
// Offsets are byte addresses on the register port; line n owns bit n.
package dbirq_pkg;
    localparam int OFS_DATA = 'h00;
    localparam int OFS_MASK = 'h04;
    localparam int OFS_POL  = 'h14;
    localparam int OFS_IEN  = 'h18;
    localparam int OFS_RAW  = 'h1C;
    localparam int OFS_MIS  = 'h20;
    localparam int OFS_CLR  = 'h24;
    localparam int OFS_ARM  = 'h28;
    localparam int OFS_DBNC = 'h40;
    localparam int DBNC_STRIDE = 4;
endpackage

// File: rtl/dbirq_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous inputs.
// Assumes each bit is unrelated to the others; no multi-bit coherence.
module dbirq_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Shift the raw inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/dbirq_filter.sv
// Settle filter for one line: the output follows the synchronised input
// only after the input has differed from it on PERIOD tick strobes in a
// row. A period of 0 acts as 1. Assumes tick is one clock wide.
module dbirq_filter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] period,
    output logic             level
);
    localparam int unsigned EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             level_q;
    logic [EXT_W-1:0] limit;
    logic [EXT_W-1:0] next_cnt;

    // Zero settle time is promoted to one tick.
    always_comb begin
        limit    = (period == '0) ? EXT_W'(1) : EXT_W'(period);
        next_cnt = EXT_W'(cnt_q) + EXT_W'(1);
    end

    // Count ticks while the input disagrees; restart when it agrees again.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (sync_in == level_q) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (next_cnt >= limit) begin
                level_q <= sync_in;
                cnt_q   <= '0;
            end else begin
                cnt_q <= next_cnt[CNT_W-1:0];
            end
        end
    end

    assign level = level_q;

    // R3
    level_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level_q));

    // R3
    level_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_q) |-> $past(sync_in));
endmodule

// File: rtl/dbirq_regs.sv
// Register file, status and arm logic for the interrupt bank.
// Holds mask-enable, active level, enable, arm, status and per-line
// settle times; produces registered read data and the combined interrupt.
// Assumes one-cycle write and read strobes and word-aligned addresses.
module dbirq_regs
    import dbirq_pkg::*;
#(
    parameter int unsigned LINES  = 8,
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        wr,
    input  logic                        rd,
    input  logic [LINES-1:0]            level,
    output logic [LINES-1:0][CNT_W-1:0] period,
    output logic [DATA_W-1:0]           rdata,
    output logic                        irq
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MIS  = ADDR_W'(OFS_MIS);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_ARM  = ADDR_W'(OFS_ARM);
    localparam int unsigned PAD_L = DATA_W - LINES;
    localparam int unsigned PAD_C = DATA_W - CNT_W;

    logic [LINES-1:0] mask_q, pol_q, ien_q, arm_q, raw_q;
    logic [LINES-1:0] active, set_vec, clr_vec, wlines;
    logic             arm_wr;
    logic [LINES-1:0] per_hit;
    logic [LINES-1:0][CNT_W-1:0] per_rd_vec;
    logic [CNT_W-1:0] per_rd;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;
    logic             unused_wdata;

    assign wlines       = wdata[LINES-1:0];
    assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

    // A line is active when its filtered level equals its active-level bit.
    always_comb begin
        active  = ~(level ^ pol_q);
        set_vec = active & arm_q;
        arm_wr  = wr && (addr == A_ARM);
        clr_vec = (wr && (addr == A_CLR)) ? wlines : '0;
    end

    // Plain read/write control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pol_q  <= '0;
            ien_q  <= '0;
        end else if (wr) begin
            if (addr == A_MASK) mask_q <= wlines;
            if (addr == A_POL)  pol_q  <= wlines;
            if (addr == A_IEN)  ien_q  <= wlines;
        end
    end

    // Sticky status: set by an armed active line, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_vec) | set_vec;
    end

    // Single-shot arm: software sets it, a status set consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_q <= '0;
        else if (arm_wr) arm_q <= wlines;
        else             arm_q <= arm_q & ~set_vec;
    end

    // One settle-time register per line, each at its own word address.
    for (genvar n = 0; n < LINES; n++) begin : g_per
        localparam logic [ADDR_W-1:0] A_N = ADDR_W'(OFS_DBNC + DBNC_STRIDE * n);
        logic [CNT_W-1:0] val_q;

        assign per_hit[n] = (addr == A_N);

        // Capture the low settle-time bits on a write to this line's word.
        always_ff @(posedge clk) begin
            if (!rst_n)                  val_q <= '0;
            else if (wr && per_hit[n])   val_q <= wdata[CNT_W-1:0];
        end

        assign period[n]     = val_q;
        assign per_rd_vec[n] = per_hit[n] ? val_q : '0;
    end

    // Merge the per-line settle-time read contributions.
    always_comb begin
        per_rd = '0;
        for (int n = 0; n < LINES; n++) per_rd = per_rd | per_rd_vec[n];
    end

    // Select the read value for the current address.
    always_comb begin
        if (addr == A_DATA)      rd_val = {{PAD_L{1'b0}}, level & mask_q};
        else if (addr == A_MASK) rd_val = {{PAD_L{1'b0}}, mask_q};
        else if (addr == A_POL)  rd_val = {{PAD_L{1'b0}}, pol_q};
        else if (addr == A_IEN)  rd_val = {{PAD_L{1'b0}}, ien_q};
        else if (addr == A_RAW)  rd_val = {{PAD_L{1'b0}}, raw_q};
        else if (addr == A_MIS)  rd_val = {{PAD_L{1'b0}}, raw_q & ien_q};
        else if (addr == A_ARM)  rd_val = {{PAD_L{1'b0}}, arm_q};
        else if (|per_hit)       rd_val = {{PAD_C{1'b0}}, per_rd};
        else                     rd_val = '0;
    end

    // Register read data on the read strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= rd_val;
    end

    assign rdata = rdata_q;
    assign irq   = |(raw_q & ien_q);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (rdata_q == '0 && raw_q == '0 && arm_q == '0));

    // R6
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec == '0) |=> ((~raw_q & $past(raw_q)) == '0));

    // R8
    arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec != '0) && !arm_wr) |=> ((arm_q & $past(set_vec)) == '0));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata_q));
endmodule

// File: rtl/dbirq_bank.sv
// Debounced level interrupt bank, top level.
// Synchronises the raw lines, filters each one against its own settle
// time counted in tick_ms strobes, and hands the filtered levels to the
// register and status block. Assumes tick_ms is a one-clock strobe.
module dbirq_bank #(
    parameter int unsigned LINES  = 8,
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic [LINES-1:0]  line_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    logic [LINES-1:0]            synced;
    logic [LINES-1:0]            level;
    logic [LINES-1:0][CNT_W-1:0] period;

    dbirq_sync #(.WIDTH(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_in),
        .sync_o  (synced)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_line
        dbirq_filter #(.CNT_W(CNT_W)) u_filter (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_ms),
            .sync_in (synced[n]),
            .period  (period[n]),
            .level   (level[n])
        );
    end

    dbirq_regs #(
        .LINES  (LINES),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .level  (level),
        .period (period),
        .rdata  (reg_rdata),
        .irq    (irq_o)
    );
endmodule

// File: tb/dbirq_bank_tb.sv
`timescale 1ns/1ps
module dbirq_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic [7:0]  line_in = '0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    int cyc_no = 0;

    always #2 clk = ~clk;

    dbirq_bank dut_i (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .line_in(line_in),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // Behavioural reference model, updated on each rising edge.
    logic [7:0]  m_s1, m_s2, m_filt, m_mask, m_pol, m_ien, m_arm, m_raw;
    int          m_cnt [8];
    int          m_per [8];
    logic [31:0] m_rdata;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a == 8'h00) return {24'd0, m_filt & m_mask};
        if (a == 8'h04) return {24'd0, m_mask};
        if (a == 8'h14) return {24'd0, m_pol};
        if (a == 8'h18) return {24'd0, m_ien};
        if (a == 8'h1C) return {24'd0, m_raw};
        if (a == 8'h20) return {24'd0, m_raw & m_ien};
        if (a == 8'h28) return {24'd0, m_arm};
        if (a >= 8'h40 && a < 8'h60 && a[1:0] == 2'b00)
            return 32'(m_per[(int'(a) - 'h40) / 4]);
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_filt = 0; m_mask = 0; m_pol = 0;
            m_ien = 0; m_arm = 0; m_raw = 0; m_rdata = 0;
            for (int i = 0; i < 8; i++) begin m_cnt[i] = 0; m_per[i] = 0; end
        end else begin
            logic [7:0] hits;
            logic [7:0] clr;
            hits = ~(m_filt ^ m_pol) & m_arm;
            clr  = (reg_wr && reg_addr == 8'h24) ? reg_wdata[7:0] : 8'h00;
            if (reg_rd) m_rdata = m_read(reg_addr);
            for (int i = 0; i < 8; i++) begin
                if (m_s2[i] == m_filt[i]) m_cnt[i] = 0;
                else if (tick_ms) begin
                    int lim;
                    lim = (m_per[i] == 0) ? 1 : m_per[i];
                    if (m_cnt[i] + 1 >= lim) begin
                        m_filt[i] = m_s2[i];
                        m_cnt[i] = 0;
                    end else m_cnt[i] = m_cnt[i] + 1;
                end
            end
            m_s2 = m_s1;
            m_s1 = line_in;
            m_raw = (m_raw & ~clr) | hits;
            if (reg_wr && reg_addr == 8'h28) m_arm = reg_wdata[7:0];
            else m_arm = m_arm & ~hits;
            if (reg_wr) begin
                if (reg_addr == 8'h04) m_mask = reg_wdata[7:0];
                if (reg_addr == 8'h14) m_pol  = reg_wdata[7:0];
                if (reg_addr == 8'h18) m_ien  = reg_wdata[7:0];
                if (reg_addr >= 8'h40 && reg_addr < 8'h60 && reg_addr[1:0] == 2'b00)
                    m_per[(int'(reg_addr) - 'h40) / 4] = int'(reg_wdata[11:0]);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // One clock: compare outputs against the model, then set the next tick.
    task automatic cyc();
        @(posedge clk);
        #1;
        chk("R2 rdata vs model", reg_rdata, m_rdata);
        chk("R7 irq_o vs model", {31'd0, irq_o}, {31'd0, |(m_raw & m_ien)});
        cyc_no++;
        tick_ms = ((cyc_no % 5) == 4);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0;
        idle(2);
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        cyc();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rdata after reset", reg_rdata, 32'd0);
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        rd_reg(8'h1C, v); chk("R1 status reset", v, 32'd0);
        rd_reg(8'h28, v); chk("R1 arm reset", v, 32'd0);
        rd_reg(8'h4C, v); chk("R1 settle reset", v, 32'd0);

        // R2: read/write registers and unmapped addresses
        wr_reg(8'h14, 32'hFFFF_FFA5);
        rd_reg(8'h14, v); chk("R2 active level readback", v, 32'hA5);
        wr_reg(8'h4C, 32'h0000_F123);
        rd_reg(8'h4C, v); chk("R2 settle width 12 bits", v, 32'h123);
        rd_reg(8'h08, v); chk("R2 unmapped reads 0", v, 32'd0);
        rd_reg(8'h24, v); chk("R2 clear reads 0", v, 32'd0);
        wr_reg(8'h1C, 32'hFF);
        rd_reg(8'h1C, v); chk("R2 read-only write ignored", v, 32'd0);
        wr_reg(8'h14, 32'h0);
        wr_reg(8'h04, 32'hFF);

        // R3: settle time of 3 ticks on line 0
        wr_reg(8'h40, 32'd3);
        line_in[0] = 1'b1;
        idle(8);
        rd_reg(8'h00, v); chk("R3 not yet settled", v & 32'h1, 32'h0);
        idle(22);
        rd_reg(8'h00, v); chk("R3 settled after period", v & 32'h1, 32'h1);

        // R3: glitch on line 1 restarts the count
        wr_reg(8'h44, 32'd4);
        line_in[1] = 1'b1; idle(12);
        line_in[1] = 1'b0; idle(4);
        line_in[1] = 1'b1; idle(14);
        rd_reg(8'h00, v); chk("R3 glitch restarts count", v & 32'h2, 32'h0);
        idle(30);
        rd_reg(8'h00, v); chk("R3 settled after glitch", v & 32'h2, 32'h2);

        // R4: settle time 0 acts as one tick
        line_in[2] = 1'b1;
        idle(1);
        rd_reg(8'h00, v); chk("R4 before sync", v & 32'h4, 32'h0);
        idle(10);
        rd_reg(8'h00, v); chk("R4 zero period one tick", v & 32'h4, 32'h4);

        // R5: data masked by mask-enable
        wr_reg(8'h04, 32'h0);
        rd_reg(8'h00, v); chk("R5 masked data reads 0", v, 32'h0);
        wr_reg(8'h04, 32'hFF);
        rd_reg(8'h00, v); chk("R5 unmasked data", v, 32'h07);

        // R9, R6, R8, R7: levels are 0x07 now
        wr_reg(8'h14, 32'h01);
        wr_reg(8'h18, 32'hFF);
        wr_reg(8'h28, 32'h03);
        rd_reg(8'h1C, v); chk("R9 active-high line sets", v, 32'h01);
        rd_reg(8'h28, v); chk("R8 arm consumed", v, 32'h02);
        chk("R7 irq high", {31'd0, irq_o}, 32'd1);
        rd_reg(8'h20, v); chk("R7 masked status", v, 32'h01);
        wr_reg(8'h24, 32'h00);
        rd_reg(8'h1C, v); chk("R6 zero clear no effect", v, 32'h01);
        wr_reg(8'h24, 32'h01);
        rd_reg(8'h1C, v); chk("R6 write-one clears", v, 32'h00);
        chk("R7 irq low after clear", {31'd0, irq_o}, 32'd0);
        idle(10);
        rd_reg(8'h1C, v); chk("R8 no set without rearm", v, 32'h00);
        wr_reg(8'h28, 32'h01);
        rd_reg(8'h1C, v); chk("R8 rearm sets again", v, 32'h01);
        wr_reg(8'h18, 32'h00);
        chk("R7 irq low when disabled", {31'd0, irq_o}, 32'd0);
        rd_reg(8'h20, v); chk("R7 masked status disabled", v, 32'h00);
        rd_reg(8'h1C, v); chk("R7 status kept when disabled", v, 32'h01);
        wr_reg(8'h24, 32'hFF);
        wr_reg(8'h14, 32'h00);
        wr_reg(8'h28, 32'h0A);
        rd_reg(8'h1C, v); chk("R9 active-low line sets", v, 32'h08);
        rd_reg(8'h28, v); chk("R9 non-matching stays armed", v, 32'h02);

        // Mixed traffic, checked against the model every cycle
        for (int k = 0; k < 3000; k++) begin
            int unsigned r;
            r = $urandom % 16;
            if (r < 3) line_in[$urandom % 8] = ~line_in[$urandom % 8];
            if (r == 4 || r == 5) begin
                logic [7:0] addrs [10];
                addrs = '{8'h04, 8'h14, 8'h18, 8'h24, 8'h28, 8'h1C,
                          8'h00, 8'h40, 8'h54, 8'h5C};
                reg_addr  = addrs[$urandom % 10];
                reg_wdata = (reg_addr >= 8'h40) ? 32'($urandom % 4) : $urandom;
                reg_wr    = 1'b1;
            end else if (r == 6 || r == 7) begin
                reg_addr = 8'($urandom % 8'h60);
                reg_rd   = 1'b1;
            end
            cyc();
            reg_wr = 1'b0;
            reg_rd = 1'b0;
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule